// File: doc/BRIEF.md
# Floating-Point Adder with Special-Value Resolution

This unit adds two single-precision (binary32) floating-point numbers in one registered step. One operand is the destination value. The other is either a binary32 value or a 16-bit two's-complement integer. The integer form is converted exactly to binary32 before the add. A 2-bit input picks one of four rounding modes. It governs the rounding of finite sums and the sign of a sum that cancels to exactly zero.

Both operands are first sorted into one of four classes: zero, normal, infinity or NaN. Inputs with a zero exponent field are flushed to a zero of the same sign. Pairs that involve a NaN, an infinity or a zero are settled by a fixed table. Pairs of normal numbers pass through an align, add and normalize datapath, which rounds with guard, round and sticky bits. Every result leaves with a one-cycle valid strobe and an invalid flag. When the caller marks an operation as the popping variant, a one-cycle pop request follows the result.

Top module: `fpadd_unit`

## Requirements
- R1: After reset, out_valid, out_sum, out_invalid and out_pop are all zero. Each cycle with in_valid high gives exactly one cycle of out_valid on the next cycle.
- R2: If either operand is a NaN (exponent all ones, fraction nonzero), the result is that NaN with fraction bit 22 forced to 1. The destination NaN wins when both operands are NaN. out_invalid stays low.
- R3: Two infinities of opposite sign produce 0x7FC00000 with out_invalid high. No other operand pair raises out_invalid.
- R4: Two infinities of the same sign return that infinity. An infinity added to a zero or a normal value returns the infinity unchanged.
- R5: Rounding-mode encoding: 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero. A sum of opposite-signed values that is exactly zero is +0 (0x00000000), except in mode 01, where it is -0 (0x80000000). This includes +0 added to -0.
- R6: Two zeros of the same sign return that zero.
- R7: A nonzero finite operand added to a zero of either sign returns the finite operand's bits unchanged.
- R8: Sums of two normal values are rounded from the exact sum to 24 significant bits according to the selected mode. Ties go to an even significand in mode 00.
- R9: On exponent overflow, modes 00 give infinity and 11 gives the largest finite value 0x7F7FFFFF (with the sign). Mode 01 gives the largest finite value for a positive sum and -infinity for a negative one. Mode 10 gives +infinity for a positive sum and the largest finite magnitude for a negative one.
- R10: An input with a zero exponent field counts as a zero of its sign. A sum whose exponent falls below 1 becomes a zero carrying the sign of the larger operand.
- R11: With in_src_is_int high, in_src_int is taken as a two's-complement integer and converted exactly. An integer zero becomes +0.
- R12: When an accepted operation has in_pop high, out_pop is high for one cycle, on the cycle after its out_valid. Otherwise out_pop stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation accepted this cycle |
| in_pop | input | 1 | Operation is the popping variant |
| in_src_is_int | input | 1 | Source comes from in_src_int instead of in_src_fp |
| in_rmode | input | 2 | Rounding mode (00 nearest, 01 down, 10 up, 11 zero) |
| in_dest | input | 32 | Destination operand, binary32 |
| in_src_fp | input | 32 | Source operand, binary32 |
| in_src_int | input | 16 | Source operand, signed integer |
| out_valid | output | 1 | Result strobe |
| out_sum | output | 32 | Result, binary32 |
| out_invalid | output | 1 | Invalid operation, valid with out_valid |
| out_pop | output | 1 | Pop request pulse |

## Verification
The sum and the invalid flag are registered once, so they appear with out_valid in the cycle after the operation is presented. The pop request arrives one cycle later still. The driver pushes the expected sum, flag and pop bit into a queue as it presents each operation. The monitor pops an entry only when out_valid is seen, at a falling edge. On the following falling edge it compares out_pop with that entry's pop bit, so the two-cycle offset of the pop is checked on its own. Back-to-back operations keep the queue full. Idle gaps confirm that no result or pop appears on its own.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  typedef enum logic [1:0] {
    FC_ZERO = 2'b00,
    FC_NORM = 2'b01,
    FC_INF  = 2'b10,
    FC_NAN  = 2'b11
  } fclass_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;
endpackage

// File: rtl/fpadd_classify.sv
module fpadd_classify
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] bits,
  output fclass_e               cls,
  output logic                  sign,
  output logic [EXP_W-1:0]      exp,
  output logic [FRAC_W-1:0]     frac
);
  localparam logic [EXP_W-1:0] EXP_ONES = '1;

  always_comb begin
    sign = bits[EXP_W+FRAC_W];
    exp  = bits[EXP_W+FRAC_W-1:FRAC_W];
    frac = bits[FRAC_W-1:0];
    if (exp == '0)
      cls = FC_ZERO;           // subnormals flushed
    else if (exp == EXP_ONES)
      cls = (frac == '0) ? FC_INF : FC_NAN;
    else
      cls = FC_NORM;
  end
endmodule

// File: rtl/fpadd_int2fp.sv
module fpadd_int2fp #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int INT_W  = 16
) (
  input  logic [INT_W-1:0]      ival,
  output logic [EXP_W+FRAC_W:0] fbits
);
  localparam int POS_W = $clog2(INT_W);
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int PAD_W = FRAC_W + 1 - INT_W;

  logic [INT_W-1:0] mag;
  logic [POS_W-1:0] pos;
  logic [FRAC_W:0]  norm;
  int               sh;

  always_comb begin
    mag = ival[INT_W-1] ? (~ival + INT_W'(1)) : ival;
    pos = '0;
    for (int i = 0; i < INT_W; i++)
      if (mag[i]) pos = POS_W'(i);
    sh   = FRAC_W - int'(pos);
    norm = {{PAD_W{1'b0}}, mag} << sh;
    // norm[FRAC_W] is the hidden bit: set for any nonzero magnitude
    if (norm[FRAC_W])
      fbits = {ival[INT_W-1], EXP_W'(BIAS + int'(pos)), norm[FRAC_W-1:0]};
    else
      fbits = '0;              // integer zero is +0
  end

  initial begin
    if (PAD_W < 0) $error("fpadd_int2fp: FRAC_W too small for INT_W");
  end
endmodule

// File: rtl/fpadd_core.sv
module fpadd_core
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  a_sign,
  input  logic [EXP_W-1:0]      a_exp,
  input  logic [FRAC_W-1:0]     a_frac,
  input  logic                  b_sign,
  input  logic [EXP_W-1:0]      b_exp,
  input  logic [FRAC_W-1:0]     b_frac,
  input  rmode_e                rmode,
  output logic [EXP_W+FRAC_W:0] sum_bits
);
  localparam int MW = FRAC_W + 1;   // significand with hidden bit
  localparam int XW = MW + 3;       // plus guard, round, sticky
  localparam int EW = EXP_W + 2;    // signed working exponent
  localparam logic [EXP_W-1:0] EXP_ONES = '1;
  localparam logic signed [EW-1:0] EXP_TOP = {2'b00, EXP_ONES};

  logic                    swap, big_s, sml_s, found, inc, ovf_inf;
  logic [EXP_W-1:0]        big_e, sml_e, diff;
  logic [XW-1:0]           big_m, sml_m, sml_sh, mask, norm;
  logic [XW:0]             raw;
  logic signed [EW-1:0]    ex;
  logic [MW:0]             rnd;
  int                      lz;

  always_comb begin
    swap  = {b_exp, b_frac} > {a_exp, a_frac};
    big_s = swap ? b_sign : a_sign;
    sml_s = swap ? a_sign : b_sign;
    big_e = swap ? b_exp : a_exp;
    sml_e = swap ? a_exp : b_exp;
    big_m = {1'b1, (swap ? b_frac : a_frac), 3'b000};
    sml_m = {1'b1, (swap ? a_frac : b_frac), 3'b000};
    diff  = big_e - sml_e;

    // align the smaller operand, folding lost bits into sticky
    mask = '0;
    if (int'(diff) >= XW) begin
      sml_sh = XW'(1);
    end else begin
      mask   = (XW'(1) << diff) - XW'(1);
      sml_sh = (sml_m >> diff) | XW'(|(sml_m & mask));
    end

    if (big_s ^ sml_s)
      raw = {1'b0, big_m} - {1'b0, sml_sh};
    else
      raw = {1'b0, big_m} + {1'b0, sml_sh};

    // leading-zero count below the carry bit
    lz    = 0;
    found = 1'b0;
    for (int i = XW - 1; i >= 0; i--) begin
      if (!found && raw[i]) begin
        lz    = XW - 1 - i;
        found = 1'b1;
      end
    end

    ex = $signed({2'b00, big_e});
    if (raw[XW]) begin
      norm = raw[XW:1] | XW'(raw[0]);
      ex   = ex + EW'(1);
    end else begin
      norm = (raw[XW-1:0] << lz) | XW'(raw[0]);
      ex   = ex - EW'(lz);
    end

    case (rmode)
      RM_NEAR: inc = norm[2] & (norm[1] | norm[0] | norm[3]);
      RM_DOWN: inc = big_s & (|norm[2:0]);
      RM_UP:   inc = ~big_s & (|norm[2:0]);
      default: inc = 1'b0;
    endcase

    rnd = {1'b0, norm[XW-1:3]} + (MW+1)'(inc);
    if (rnd[MW]) ex = ex + EW'(1);

    case (rmode)
      RM_NEAR: ovf_inf = 1'b1;
      RM_DOWN: ovf_inf = big_s;
      RM_UP:   ovf_inf = ~big_s;
      default: ovf_inf = 1'b0;
    endcase

    // a nonzero aligned sum always leaves bit MW-1 or the carry set
    if (!(rnd[MW] | rnd[MW-1]))
      sum_bits = {(rmode == RM_DOWN), (EXP_W+FRAC_W)'(0)};
    else if (ex < EW'(1))
      sum_bits = {big_s, (EXP_W+FRAC_W)'(0)};
    else if (ex >= EXP_TOP)
      sum_bits = ovf_inf ? {big_s, EXP_ONES, FRAC_W'(0)}
                         : {big_s, EXP_ONES - EXP_W'(1), {FRAC_W{1'b1}}};
    else
      sum_bits = {big_s, ex[EXP_W-1:0], rnd[FRAC_W-1:0]};
  end
endmodule

// File: rtl/fpadd_unit.sv
module fpadd_unit
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int INT_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic                  in_pop,
  input  logic                  in_src_is_int,
  input  logic [1:0]            in_rmode,
  input  logic [EXP_W+FRAC_W:0] in_dest,
  input  logic [EXP_W+FRAC_W:0] in_src_fp,
  input  logic [INT_W-1:0]      in_src_int,
  output logic                  out_valid,
  output logic [EXP_W+FRAC_W:0] out_sum,
  output logic                  out_invalid,
  output logic                  out_pop
);
  localparam int W = EXP_W + FRAC_W + 1;
  localparam logic [EXP_W-1:0] EXP_ONES = '1;
  localparam logic [W-1:0] QNAN = {1'b0, EXP_ONES, 1'b1, (FRAC_W-1)'(0)};

  rmode_e              rm;
  logic [W-1:0]        int_bits, src_bits, core_sum, res;
  fclass_e             d_cls, s_cls;
  logic                d_sign, s_sign, inv, pop_pend;
  logic [EXP_W-1:0]    d_exp, s_exp;
  logic [FRAC_W-1:0]   d_frac, s_frac;

  assign rm = rmode_e'(in_rmode);

  fpadd_int2fp #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_cvt (
    .ival (in_src_int),
    .fbits(int_bits)
  );

  assign src_bits = in_src_is_int ? int_bits : in_src_fp;

  fpadd_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_d (
    .bits(in_dest), .cls(d_cls), .sign(d_sign), .exp(d_exp), .frac(d_frac)
  );

  fpadd_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_s (
    .bits(src_bits), .cls(s_cls), .sign(s_sign), .exp(s_exp), .frac(s_frac)
  );

  fpadd_core #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_core (
    .a_sign(d_sign), .a_exp(d_exp), .a_frac(d_frac),
    .b_sign(s_sign), .b_exp(s_exp), .b_frac(s_frac),
    .rmode(rm), .sum_bits(core_sum)
  );

  // special-value resolution; NaN first, destination preferred
  always_comb begin
    inv = 1'b0;
    res = core_sum;
    if (d_cls == FC_NAN)
      res = {d_sign, EXP_ONES, 1'b1, d_frac[FRAC_W-2:0]};
    else if (s_cls == FC_NAN)
      res = {s_sign, EXP_ONES, 1'b1, s_frac[FRAC_W-2:0]};
    else if (d_cls == FC_INF && s_cls == FC_INF) begin
      if (d_sign != s_sign) begin
        res = QNAN;
        inv = 1'b1;
      end else
        res = {d_sign, EXP_ONES, FRAC_W'(0)};
    end
    else if (d_cls == FC_INF)
      res = {d_sign, EXP_ONES, FRAC_W'(0)};
    else if (s_cls == FC_INF)
      res = {s_sign, EXP_ONES, FRAC_W'(0)};
    else if (d_cls == FC_ZERO && s_cls == FC_ZERO)
      res = (d_sign == s_sign) ? {d_sign, (W-1)'(0)}
                               : {(rm == RM_DOWN), (W-1)'(0)};
    else if (d_cls == FC_ZERO)
      res = src_bits;
    else if (s_cls == FC_ZERO)
      res = in_dest;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_sum     <= '0;
      out_invalid <= 1'b0;
      pop_pend    <= 1'b0;
      out_pop     <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      out_invalid <= in_valid & inv;
      if (in_valid) out_sum <= res;
      pop_pend    <= in_valid & in_pop;
      out_pop     <= pop_pend;
    end
  end

  p_valid_lat_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_inv_qnan_r3: assert property (@(posedge clk) disable iff (rst)
    out_invalid |-> (out_valid && out_sum == QNAN));

  p_nan_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sum[W-2:FRAC_W] == EXP_ONES && out_sum[FRAC_W-1:0] != '0)
      |-> out_sum[FRAC_W-1]);

  p_pop_after_r12: assert property (@(posedge clk) disable iff (rst)
    out_pop |-> $past(out_valid));

  p_pop_single_r12: assert property (@(posedge clk) disable iff (rst)
    out_pop |=> !out_pop || $past(out_valid));
endmodule

// File: tb/sim_fpadd_unit.sv
module sim_fpadd_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_pop = 1'b0, in_src_is_int = 1'b0;
  logic [1:0]  in_rmode = 2'b00;
  logic [31:0] in_dest = '0, in_src_fp = '0;
  logic [15:0] in_src_int = '0;
  logic        out_valid, out_invalid, out_pop;
  logic [31:0] out_sum;

  typedef struct {
    logic [31:0] sum;
    logic        inv;
    logic        pop;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0, errors = 0;
  bit   done = 0, started = 0;
  bit   pend_chk = 0, pend_pop = 0;
  string pend_tag = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  fpadd_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_pop(in_pop),
    .in_src_is_int(in_src_is_int), .in_rmode(in_rmode), .in_dest(in_dest),
    .in_src_fp(in_src_fp), .in_src_int(in_src_int), .out_valid(out_valid),
    .out_sum(out_sum), .out_invalid(out_invalid), .out_pop(out_pop)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  task automatic send(input logic [31:0] d, input logic [31:0] s, input logic isint,
                      input logic [15:0] iv, input logic [1:0] rm, input logic pop,
                      input logic [31:0] es, input logic ei, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_dest = d; in_src_fp = s; in_src_is_int = isint;
    in_src_int = iv; in_rmode = rm; in_pop = pop;
    q.push_back('{es, ei, pop, tag});
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0; in_pop = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  // monitor: results due one cycle after issue, pop one cycle after result
  always @(negedge clk) begin
    if (started && !rst) begin
      if (pend_chk)
        chk({pend_tag, " R12 pop"}, {63'd0, out_pop}, {63'd0, pend_pop});
      pend_chk = out_valid;
      pend_pop = 1'b0;
      if (out_valid) begin
        if (q.size() == 0) begin
          chk("R1 unexpected out_valid", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(e.tag, {31'd0, out_invalid, out_sum}, {31'd0, e.inv, e.sum});
          pend_pop = e.pop;
          pend_tag = e.tag;
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {63'd0, out_valid}, 64'd0);
    chk("R1 reset sum", {32'd0, out_sum}, 64'd0);
    chk("R1 reset flags", {62'd0, out_invalid, out_pop}, 64'd0);
    rst = 1'b0;
    started = 1;

    // R8 normal sums
    send(32'h3F800000, 32'h40000000, 0, 0, 2'b00, 0, 32'h40400000, 0, "R8 1+2");
    send(32'h3F800000, 32'h3F800000, 0, 0, 2'b00, 1, 32'h40000000, 0, "R8 1+1 pop");
    send(32'h3FC00000, 32'hBF000000, 0, 0, 2'b00, 0, 32'h3F800000, 0, "R8 1.5-0.5");
    send(32'h3F800000, 32'hBF400000, 0, 0, 2'b00, 0, 32'h3E800000, 0, "R8 1-0.75");
    send(32'h3F800000, 32'hB3800000, 0, 0, 2'b00, 0, 32'h3F7FFFFF, 0, "R8 1-2^-24");
    // R8 rounding modes: 1 + 2^-24 is a tie
    send(32'h3F800000, 32'h33800000, 0, 0, 2'b00, 0, 32'h3F800000, 0, "R8 tie near");
    send(32'h3F800000, 32'h33800000, 0, 0, 2'b10, 0, 32'h3F800001, 0, "R8 tie up");
    send(32'h3F800000, 32'h33800000, 0, 0, 2'b11, 0, 32'h3F800000, 0, "R8 tie zero");
    send(32'h3F800000, 32'h33800000, 0, 0, 2'b01, 0, 32'h3F800000, 0, "R8 tie down");
    send(32'h3F800000, 32'h33C00000, 0, 0, 2'b00, 0, 32'h3F800001, 0, "R8 above half near");
    send(32'hBF800000, 32'hB3800000, 0, 0, 2'b01, 0, 32'hBF800001, 0, "R8 neg down");
    send(32'hBF800000, 32'hB3800000, 0, 0, 2'b10, 0, 32'hBF800000, 0, "R8 neg up");
    send(32'h3F800000, 32'h00800000, 0, 0, 2'b10, 0, 32'h3F800001, 0, "R8 far sticky up");
    send(32'h3F800000, 32'h80800000, 0, 0, 2'b00, 0, 32'h3F800000, 0, "R8 far sub near");
    send(32'h3F800000, 32'h80800000, 0, 0, 2'b11, 0, 32'h3F7FFFFF, 0, "R8 far sub zero");
    idle(2);
    // R5 exact cancellation
    send(32'h3F800000, 32'hBF800000, 0, 0, 2'b00, 0, 32'h00000000, 0, "R5 cancel near");
    send(32'h3F800000, 32'hBF800000, 0, 0, 2'b01, 1, 32'h80000000, 0, "R5 cancel down");
    send(32'h3F800000, 32'hBF800000, 0, 0, 2'b10, 0, 32'h00000000, 0, "R5 cancel up");
    send(32'h3F800000, 32'hBF800000, 0, 0, 2'b11, 0, 32'h00000000, 0, "R5 cancel zero");
    send(32'h00000000, 32'h80000000, 0, 0, 2'b00, 0, 32'h00000000, 0, "R5 +0-0 near");
    send(32'h00000000, 32'h80000000, 0, 0, 2'b01, 0, 32'h80000000, 0, "R5 +0-0 down");
    // R6 same-sign zeros
    send(32'h80000000, 32'h80000000, 0, 0, 2'b00, 0, 32'h80000000, 0, "R6 -0-0");
    send(32'h00000000, 32'h00000000, 0, 0, 2'b01, 0, 32'h00000000, 0, "R6 +0+0 down");
    // R3, R4 infinities
    send(32'h7F800000, 32'hFF800000, 0, 0, 2'b00, 0, 32'h7FC00000, 1, "R3 inf-inf");
    send(32'hFF800000, 32'h7F800000, 0, 0, 2'b01, 1, 32'h7FC00000, 1, "R3 -inf+inf");
    send(32'h7F800000, 32'h7F800000, 0, 0, 2'b00, 0, 32'h7F800000, 0, "R4 inf+inf");
    send(32'hFF800000, 32'hFF800000, 0, 0, 2'b00, 0, 32'hFF800000, 0, "R4 -inf-inf");
    send(32'h7F800000, 32'h3F800000, 0, 0, 2'b00, 0, 32'h7F800000, 0, "R4 inf+1");
    send(32'h3F800000, 32'hFF800000, 0, 0, 2'b00, 0, 32'hFF800000, 0, "R4 1-inf");
    send(32'h80000000, 32'h7F800000, 0, 0, 2'b00, 0, 32'h7F800000, 0, "R4 -0+inf");
    // R2 NaNs
    send(32'h7F800001, 32'h3F800000, 0, 0, 2'b00, 0, 32'h7FC00001, 0, "R2 dest snan");
    send(32'h3F800000, 32'hFFA00000, 0, 0, 2'b00, 0, 32'hFFE00000, 0, "R2 src nan");
    send(32'h7FC00005, 32'hFFC00000, 0, 0, 2'b00, 0, 32'h7FC00005, 0, "R2 both nan");
    send(32'h7F800000, 32'hFF800001, 0, 0, 2'b00, 0, 32'hFFC00001, 0, "R2 nan beats inf");
    // R7 finite + zero
    send(32'h40490FDB, 32'h80000000, 0, 0, 2'b01, 0, 32'h40490FDB, 0, "R7 x+(-0)");
    send(32'h00000000, 32'hC0490FDB, 0, 0, 2'b00, 0, 32'hC0490FDB, 0, "R7 0+x");
    idle(3);
    // R9 overflow
    send(32'h7F7FFFFF, 32'h7F7FFFFF, 0, 0, 2'b00, 0, 32'h7F800000, 0, "R9 ovf near");
    send(32'h7F7FFFFF, 32'h7F7FFFFF, 0, 0, 2'b11, 0, 32'h7F7FFFFF, 0, "R9 ovf zero");
    send(32'h7F7FFFFF, 32'h7F7FFFFF, 0, 0, 2'b01, 0, 32'h7F7FFFFF, 0, "R9 ovf down pos");
    send(32'h7F7FFFFF, 32'h7F7FFFFF, 0, 0, 2'b10, 0, 32'h7F800000, 0, "R9 ovf up pos");
    send(32'hFF7FFFFF, 32'hFF7FFFFF, 0, 0, 2'b10, 0, 32'hFF7FFFFF, 0, "R9 ovf up neg");
    send(32'hFF7FFFFF, 32'hFF7FFFFF, 0, 0, 2'b01, 0, 32'hFF800000, 0, "R9 ovf down neg");
    // R10 flush
    send(32'h00000001, 32'h3F800000, 0, 0, 2'b00, 0, 32'h3F800000, 0, "R10 denorm in");
    send(32'h00000001, 32'h80000001, 0, 0, 2'b00, 0, 32'h00000000, 0, "R10 denorms");
    send(32'h00800000, 32'h80C00000, 0, 0, 2'b00, 0, 32'h80000000, 0, "R10 tiny out");
    // R11 integer source
    send(32'h3F800000, 32'h0, 1, 16'd3, 2'b00, 0, 32'h40800000, 0, "R11 1+int3");
    send(32'h40200000, 32'h0, 1, 16'hFFFB, 2'b00, 0, 32'hC0200000, 0, "R11 2.5+int-5");
    send(32'h00000000, 32'h0, 1, 16'h8000, 2'b00, 0, 32'hC7000000, 0, "R11 int min");
    send(32'h80000000, 32'hFF800000, 1, 16'd0, 2'b00, 0, 32'h00000000, 0, "R11 -0+int0 near");
    send(32'h80000000, 32'h0, 1, 16'd0, 2'b01, 0, 32'h80000000, 0, "R11 -0+int0 down");
    send(32'h40A00000, 32'h0, 1, 16'd0, 2'b00, 1, 32'h40A00000, 0, "R11 5+int0");
    idle(6);
    chk("R1 queue drained", {32'd0, 32'(q.size())}, 64'd0);
    chk("R12 no stray pop", {63'd0, out_pop}, 64'd0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule